// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Automatic Level Masking

This block gathers a set of interrupt request lines and tells a processor core which interrupt level it should take next. Each source has its own enable bit and a programmable 3-bit level. The controller picks the highest-level source that is pending, enabled and not blocked by the current level mask. It drives that level to the core, and level 0 means nothing is requested. A wake-up output goes high whenever any enabled source is pending, so that low-power logic can restart clocks.

When the core takes an interrupt it pulses an acknowledge strobe, and one cycle later the controller presents a vector. That vector is a base value plus the winning source index, or a fixed spurious value if nothing was eligible. If automatic level masking is switched on, the acknowledge also raises the current level mask to the level being serviced and keeps the old mask in a save register. Requests at that level or below then stay blocked until software writes the software-acknowledge address, which puts the saved value back.

Software reaches every register through a simple bus with a write strobe, an address, write data and combinational read data.

Top module: `intc_top`

## Requirements
- R1: After reset the source mask reads all ones (every source masked), the configuration reads 0, the current and saved level masks both read 0xF, and irq_level and wake are 0 whatever req is.
- R2: The source mask lives at address 0, and bit i holds source i, with 1 meaning masked. A source whose bit is 1 is never presented on irq_level or ack_vector.
- R3: The level of source i lives at address 8+i in bits [2:0]. A source whose level is 0 is never presented.
- R4: irq_level equals the highest level among the eligible sources, or 0 if there are none. Eligible means pending, unmasked, level nonzero and passing the level mask. When several eligible sources share that level, the lowest-numbered one wins.
- R5: The current level mask lives at address 2 in bits [3:0]. When it is 0xF every level passes. Otherwise a source passes only if its level is strictly greater than the mask.
- R6: On the clock edge where iack is high, ack_vector is loaded. It becomes VEC_BASE (64) plus the winning index, or SPUR_VEC (15) if no source is eligible. It holds that value until the next acknowledge.
- R7: The configuration lives at address 1, and bit 0 enables automatic level masking. With the bit set, an acknowledge that has a winner at level n loads the current mask with n and copies the previous current mask into the saved mask at address 3. With the bit clear, or with no winner, both masks stay unchanged.
- R8: Any write to address 4 is a software acknowledge: it copies the saved mask into the current mask.
- R9: wake is 1 exactly when some source is both pending and unmasked. Its level and the level mask do not affect it.
- R10: Reads return the register contents zero-extended to 8 bits. Addresses with no register, such as 5 to 7 and 16 to 31, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 8 | Interrupt request lines, one per source |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| iack | input | 1 | Interrupt acknowledge strobe from the core |
| ack_vector | output | 8 | Vector returned for the last acknowledge |
| irq_level | output | 3 | Level requested of the core, 0 when none |
| wake | output | 1 | Wake-up request to low-power control |

## Verification
A corrupted mask or level register shows at once, on the next read of that address and in a wrong irq_level for a request pattern that involves that source. A wrong arbitration or tie-break is visible in the same cycle on irq_level, and one cycle after an acknowledge on ack_vector. An error in the current or saved level mask shows as blocked or leaking levels right after the acknowledge edge, or after the software acknowledge restores the wrong value. It can also be read back directly at addresses 2 and 3.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LW = 3;
  localparam int MW = 4;
  localparam logic [MW-1:0] MASK_NONE = 4'hF;
  localparam int ADR_SRCMASK = 0;
  localparam int ADR_CFG     = 1;
  localparam int ADR_CUR     = 2;
  localparam int ADR_SAVED   = 3;
  localparam int ADR_SWACK   = 4;
  localparam int LVL_BASE    = 8;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int AW   = 5,
  parameter int DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [NSRC-1:0]          src_mask,
  output logic [NSRC-1:0][LW-1:0]  src_lvl,
  output logic                     cfg_lvl_en
);
  logic            mask_en, cfg_en;
  logic [NSRC-1:0] mask_d;
  logic            cfg_d;

  always_comb begin
    mask_en = we && (addr == AW'(ADR_SRCMASK));
    cfg_en  = we && (addr == AW'(ADR_CFG));
    mask_d  = mask_en ? wdata[NSRC-1:0] : src_mask;
    cfg_d   = cfg_en ? wdata[0] : cfg_lvl_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_mask   <= '1;
      cfg_lvl_en <= 1'b0;
    end else begin
      src_mask   <= mask_d;
      cfg_lvl_en <= cfg_d;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    logic          lvl_en;
    logic [LW-1:0] lvl_d;
    always_comb begin
      lvl_en = we && (addr == AW'(LVL_BASE + g));
      lvl_d  = lvl_en ? wdata[LW-1:0] : src_lvl[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_lvl[g] <= '0;
      else        src_lvl[g] <= lvl_d;
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]          req,
  input  logic [NSRC-1:0]          src_mask,
  input  logic [NSRC-1:0][LW-1:0]  src_lvl,
  input  logic [MW-1:0]            cur_mask,
  output logic                     win_valid,
  output logic [LW-1:0]            win_lvl,
  output logic [IW-1:0]            win_idx,
  output logic                     wake
);
  logic [NSRC-1:0] live, elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    always_comb begin
      live[g] = req[g] && !src_mask[g];
      elig[g] = live[g] && (src_lvl[g] != '0) &&
                ((cur_mask == MASK_NONE) || ({1'b0, src_lvl[g]} > cur_mask));
    end
  end

  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (src_lvl[i] >= win_lvl)) begin
        win_lvl = src_lvl[i];
        win_idx = IW'(i);
      end
    end
    win_valid = |elig;
    wake      = |live;
  end
endmodule

// File: rtl/intc_lvlmask.sv
module intc_lvlmask
  import intc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ack_take,
  input  logic [LW-1:0]  ack_lvl,
  input  logic           swack,
  input  logic           cur_we,
  input  logic           sav_we,
  input  logic [MW-1:0]  wdata,
  output logic [MW-1:0]  cur_q,
  output logic [MW-1:0]  sav_q
);
  logic [MW-1:0] cur_d, sav_d;

  always_comb begin
    cur_d = cur_q;
    sav_d = sav_q;
    if (ack_take) begin
      sav_d = cur_q;
      cur_d = {1'b0, ack_lvl};
    end else if (swack) begin
      cur_d = sav_q;
    end else begin
      if (cur_we) cur_d = wdata;
      if (sav_we) sav_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= MASK_NONE;
      sav_q <= MASK_NONE;
    end else begin
      cur_q <= cur_d;
      sav_q <= sav_d;
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int AW   = 5,
  parameter int DW   = 8,
  parameter int VW   = 8,
  parameter logic [VW-1:0] VEC_BASE = 8'd64,
  parameter logic [VW-1:0] SPUR_VEC = 8'd15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            iack,
  output logic [VW-1:0]   ack_vector,
  output logic [LW-1:0]   irq_level,
  output logic            wake
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NSRC-1:0]         src_mask;
  logic [NSRC-1:0][LW-1:0] src_lvl;
  logic                    cfg_lvl_en;
  logic                    win_valid;
  logic [LW-1:0]           win_lvl;
  logic [IW-1:0]           win_idx;
  logic [MW-1:0]           cur_mask_q, sav_mask_q;
  logic                    ack_take, swack, cur_we, sav_we;
  logic [VW-1:0]           vec_d;

  intc_regs #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .src_mask(src_mask), .src_lvl(src_lvl), .cfg_lvl_en(cfg_lvl_en)
  );

  intc_arb #(.NSRC(NSRC)) u_arb (
    .req(req), .src_mask(src_mask), .src_lvl(src_lvl), .cur_mask(cur_mask_q),
    .win_valid(win_valid), .win_lvl(win_lvl), .win_idx(win_idx), .wake(wake)
  );

  always_comb begin
    ack_take = iack && cfg_lvl_en && win_valid;
    swack    = bus_we && (bus_addr == AW'(ADR_SWACK));
    cur_we   = bus_we && (bus_addr == AW'(ADR_CUR));
    sav_we   = bus_we && (bus_addr == AW'(ADR_SAVED));
  end

  intc_lvlmask u_lvlmask (
    .clk(clk), .rst_n(rst_sync_n), .ack_take(ack_take), .ack_lvl(win_lvl),
    .swack(swack), .cur_we(cur_we), .sav_we(sav_we), .wdata(bus_wdata[MW-1:0]),
    .cur_q(cur_mask_q), .sav_q(sav_mask_q)
  );

  always_comb begin
    vec_d = ack_vector;
    if (iack) vec_d = win_valid ? (VEC_BASE + VW'(win_idx)) : SPUR_VEC;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ack_vector <= SPUR_VEC;
    else             ack_vector <= vec_d;
  end

  assign irq_level = win_lvl;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(ADR_SRCMASK): bus_rdata = DW'(src_mask);
      AW'(ADR_CFG):     bus_rdata = DW'(cfg_lvl_en);
      AW'(ADR_CUR):     bus_rdata = DW'(cur_mask_q);
      AW'(ADR_SAVED):   bus_rdata = DW'(sav_mask_q);
      default: begin
        for (int i = 0; i < NSRC; i++)
          if (bus_addr == AW'(LVL_BASE + i)) bus_rdata = DW'(src_lvl[i]);
      end
    endcase
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int AW = 5,
  parameter int VW = 8,
  parameter logic [VW-1:0] SPUR_VEC = 8'd15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iack,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [LW-1:0] irq_level,
  input logic          wake,
  input logic [VW-1:0] ack_vector,
  input logic          cfg_en,
  input logic [MW-1:0] cur_mask,
  input logic [MW-1:0] sav_mask
);
  assert_level_implies_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> wake);

  assert_level_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mask != MASK_NONE && irq_level != '0) |-> ({1'b0, irq_level} > cur_mask));

  assert_spurious_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && irq_level == '0) |=> (ack_vector == SPUR_VEC));

  assert_ack_raises_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && cfg_en && irq_level != '0) |=> (cur_mask == {1'b0, $past(irq_level)}));

  assert_ack_saves_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && cfg_en && irq_level != '0) |=> (sav_mask == $past(cur_mask)));

  assert_swack_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(ADR_SWACK) && !iack) |=> (cur_mask == $past(sav_mask)));
endmodule

bind intc_top intc_chk #(.AW(AW), .VW(VW), .SPUR_VEC(SPUR_VEC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .iack(iack), .bus_we(bus_we), .bus_addr(bus_addr),
  .irq_level(irq_level), .wake(wake), .ack_vector(ack_vector), .cfg_en(cfg_lvl_en),
  .cur_mask(cur_mask_q), .sav_mask(sav_mask_q)
);

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;
  localparam int N = 8;
  localparam real TCK = 4.0;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         bus_we;
  logic [4:0]   bus_addr;
  logic [7:0]   bus_wdata;
  logic [7:0]   bus_rdata;
  logic         iack;
  logic [7:0]   ack_vector;
  logic [2:0]   irq_level;
  logic         wake;

  int n_cmp = 0;
  int n_bad = 0;

  logic [N-1:0] m_mask;
  logic [2:0]   m_lvl [N];
  logic [3:0]   m_cur, m_sav;

  always #(TCK/2) clk = ~clk;

  intc_top i_intc_top (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iack(iack),
    .ack_vector(ack_vector), .irq_level(irq_level), .wake(wake)
  );

  task automatic check(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int exp_lvl(input logic [N-1:0] r);
    int best = 0;
    for (int i = 0; i < N; i++)
      if (r[i] && !m_mask[i] && m_lvl[i] != 0 && (m_cur == 4'hF || int'(m_lvl[i]) > int'(m_cur))
          && int'(m_lvl[i]) > best) best = m_lvl[i];
    return best;
  endfunction

  function automatic int exp_vec(input logic [N-1:0] r);
    int best = 0;
    int idx = -1;
    for (int i = 0; i < N; i++)
      if (r[i] && !m_mask[i] && m_lvl[i] != 0 && (m_cur == 4'hF || int'(m_lvl[i]) > int'(m_cur))
          && int'(m_lvl[i]) > best) begin
        best = m_lvl[i];
        idx = i;
      end
    return (idx < 0) ? 15 : 64 + idx;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string rq, input int a, input int exp);
    bus_addr = 5'(a);
    #0.5;
    check(rq, bus_rdata, exp);
  endtask

  task automatic do_ack(input string rq);
    int ev, el;
    ev = exp_vec(req);
    el = exp_lvl(req);
    @(negedge clk);
    iack = 1'b1;
    @(negedge clk);
    iack = 1'b0;
    check(rq, ack_vector, ev);
    if (el != 0 && i_cfg_on) begin
      m_sav = m_cur;
      m_cur = 4'(el);
    end
  endtask

  bit i_cfg_on = 1'b0;

  initial begin
    #(TCK * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; iack = 1'b0;
    m_mask = '1; m_cur = 4'hF; m_sav = 4'hF;
    for (int i = 0; i < N; i++) m_lvl[i] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    req = '1;
    #0.5;
    check("R1 irq_level", irq_level, 0);
    check("R1 wake", wake, 0);
    rd_check("R1 mask", 0, 255);
    rd_check("R1 cfg", 1, 0);
    rd_check("R1 cur", 2, 15);
    rd_check("R1 saved", 3, 15);

    // R9/R3: unmask one source at a time with level 0
    for (int i = 0; i < N; i++) begin
      m_mask = ~(8'(1) << i);
      wr(0, m_mask);
      req = 8'(1) << i;
      #0.5;
      check("R9 wake single", wake, 1);
      check("R3 level zero hidden", irq_level, 0);
      req = ~(8'(1) << i);
      #0.5;
      check("R9 wake masked others", wake, 0);
    end

    // R3/R10 program and read back levels
    for (int i = 0; i < N; i++) begin
      m_lvl[i] = 3'((i * 3 + 1) % 8);
      wr(8 + i, m_lvl[i]);
    end
    for (int i = 0; i < N; i++) rd_check("R10 level readback", 8 + i, m_lvl[i]);
    rd_check("R10 unused 5", 5, 0);
    rd_check("R10 unused 7", 7, 0);
    rd_check("R10 unused 16", 16, 0);
    rd_check("R10 unused 31", 31, 0);

    // R2 partial mask sweep, then R4/R6 full sweep
    m_mask = 8'hA5;
    wr(0, m_mask);
    rd_check("R10 mask readback", 0, 8'hA5);
    for (int p = 0; p < 256; p++) begin
      req = 8'(p);
      #0.5;
      check("R2 masked sources", irq_level, exp_lvl(req));
      check("R9 wake pattern", wake, |(req & ~m_mask));
    end
    m_mask = '0;
    wr(0, 0);
    for (int p = 0; p < 256; p++) begin
      req = 8'(p);
      #0.5;
      check("R4 highest level", irq_level, exp_lvl(req));
      do_ack("R6 vector");
    end
    rd_check("R7 cur unchanged cfg off", 2, 15);

    // R4 tie break: equal levels
    for (int i = 0; i < N; i++) begin m_lvl[i] = 3'd5; wr(8 + i, 5); end
    for (int p = 1; p < 256; p++) begin
      req = 8'(p);
      do_ack("R4 tie lowest index");
    end
    for (int i = 0; i < N; i++) begin
      m_lvl[i] = 3'((i * 3 + 1) % 8);
      wr(8 + i, m_lvl[i]);
    end

    // R5 level mask sweep
    for (int c = 0; c < 8; c++) begin
      m_cur = 4'(c);
      wr(2, c);
      for (int p = 0; p < 256; p++) begin
        req = 8'(p);
        #0.5;
        check("R5 level mask filter", irq_level, exp_lvl(req));
      end
    end
    m_cur = 4'hF;
    wr(2, 15);

    // R7/R8 automatic masking
    i_cfg_on = 1'b1;
    wr(1, 1);
    rd_check("R10 cfg readback", 1, 1);
    for (int i = 0; i < N; i++) begin
      if (m_lvl[i] != 0) begin
        req = 8'(1) << i;
        do_ack("R7 vector");
        rd_check("R7 cur raised", 2, m_lvl[i]);
        rd_check("R7 saved", 3, 15);
        for (int p = 0; p < 256; p++) begin
          req = 8'(p);
          #0.5;
          check("R7 blocked at or below", irq_level, exp_lvl(req));
        end
        wr(4, 0);
        m_cur = m_sav;
        rd_check("R8 restored", 2, 15);
      end
    end
    // nested: level 2 then level 7
    req = 8'b0000_1000;
    do_ack("R7 nested first");
    req = 8'b0000_1100;
    do_ack("R7 nested second");
    rd_check("R7 nested cur", 2, 7);
    rd_check("R7 nested saved", 3, 2);
    wr(4, 0);
    m_cur = m_sav;
    rd_check("R8 nested restore", 2, 2);
    // spurious with masking on
    req = '0;
    do_ack("R6 spurious");
    rd_check("R7 spurious keeps cur", 2, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule